// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Data Port

This block lets a processor reach a 128 KiB work RAM through a single byte-wide data register instead of through the RAM's own address space. Software first sets up a 17-bit pointer by writing three byte-wide pointer registers: a low byte, a middle byte and a top register. Only bit 0 of the top register's data is used. Each later read or write of the data register then accesses the RAM byte at the pointer. The pointer advances by one after every such access, so a block of RAM can be streamed in or out with repeated accesses to one address.

The processor side is a simple register bus: an address, write data, a read strobe and a write strobe, plus a read-data output with a valid pulse. The RAM side is a synchronous master port with one cycle of read latency. The RAM address it drives is the pointer placed in a fixed bank region based at 0x7E0000. The RAM array is not part of the block.

Sequencing uses five named states. `ST_IDLE` accepts a data-port access. Transition *write accept* leads from `ST_IDLE` to `ST_WR_COMMIT`, where the RAM write enable is high for one cycle, and transition *write retire* returns to `ST_IDLE`. Transition *read accept* leads from `ST_IDLE` to `ST_RD_ADDR`, where the RAM samples the address. Transition *read fetch* leads to `ST_RD_LATCH`, where the returned byte is captured. Transition *read capture* leads to `ST_RD_DONE`, where the byte is presented with a valid pulse. Transition *read retire* returns to `ST_IDLE`. Pointer-register writes are accepted in every state.

Top module: `wram_port`

## Requirements
- R1: After reset, `port_busy`, `bus_rvalid` and `ram_we` are 0, and the pointer is 0, so the first data write goes to RAM address 0x7E0000.
- R2: A bus write to offset 0x2181 loads pointer bits 7:0 from the write data and leaves bits 16:8 unchanged.
- R3: A bus write to offset 0x2182 loads pointer bits 15:8 and leaves bits 16 and 7:0 unchanged.
- R4: A bus write to offset 0x2183 loads only pointer bit 16, from write-data bit 0. Write-data bits 7:1 have no effect, and pointer bits 15:0 are unchanged.
- R5: A bus write to offset 0x2180 in `ST_IDLE` drives `ram_we` high for exactly the next cycle. In that cycle the RAM address is 0x7E0000 OR the pointer and the RAM write data is the bus byte. The pointer then increments.
- R6: A bus read of offset 0x2180 in `ST_IDLE` drives the RAM address in the next cycle. The RAM byte at the old pointer appears on `bus_rdata` with `bus_rvalid` high in the third cycle after the strobe, for one cycle. The pointer increments.
- R7: The pointer wraps from 0x1FFFF to 0x00000.
- R8: A pointer-register write made during a read in progress, including in its completion cycle, does not change the byte returned. The resulting pointer is exactly the written value, with no further increment.
- R9: `port_busy` is high in every state other than `ST_IDLE`. It is high whenever `bus_rvalid` is high and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rdata | output | 8 | Byte returned by a data-port read |
| bus_rvalid | output | 1 | One-cycle pulse marking `bus_rdata` valid |
| port_busy | output | 1 | A data-port access is in progress |
| ram_addr | output | 24 | RAM address, bank base OR pointer |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |
| ram_we | output | 1 | RAM write enable |

## Verification
The assertions assume that the processor never raises the read and write strobes in the same cycle. They also assume it issues no data-port access while `port_busy` is high; pointer-register writes are still allowed at any time. The stimulus keeps within these limits. Every bus operation is a single-cycle strobe driven from one task, and each data-port access waits for the block to return to idle before the next one begins. The only access made while busy is the deliberate pointer write in the R8 test.

// File: rtl/wram_port_pkg.sv
package wram_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_COMMIT,
        ST_RD_ADDR,
        ST_RD_LATCH,
        ST_RD_DONE
    } port_state_t;

endpackage

// File: rtl/wram_port_decode.sv
module wram_port_decode #(
    parameter int                 BUS_AW    = 16,
    parameter logic [BUS_AW-1:0]  PORT_BASE = 16'h2180,
    parameter int                 NLANES    = 3
) (
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic              data_rd,
    output logic              data_wr,
    output logic [NLANES-1:0] lane_ld
);

    logic hit_data;

    assign hit_data = (bus_addr == PORT_BASE);
    assign data_rd  = bus_rd && hit_data;
    assign data_wr  = bus_wr && hit_data;

    // pointer byte registers sit at consecutive offsets above the data port
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam logic [BUS_AW-1:0] LANE_OFF = PORT_BASE + BUS_AW'(g + 1);
        assign lane_ld[g] = bus_wr && (bus_addr == LANE_OFF);
    end

endmodule

// File: rtl/wram_ptr_reg.sv
module wram_ptr_reg #(
    parameter int PTR_W  = 17,
    parameter int NLANES = (PTR_W + 7) / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLANES-1:0] lane_ld,
    input  logic [7:0]        ld_data,
    input  logic              inc,
    output logic [PTR_W-1:0]  ptr
);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_stepped;
    logic [PTR_W-1:0] ld_mask;
    logic [PTR_W-1:0] ld_bits;

    // each lane covers up to eight pointer bits; the top lane may be narrower
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LO = 8 * g;
        localparam int W  = ((PTR_W - LO) < 8) ? (PTR_W - LO) : 8;
        assign ld_mask[LO +: W] = {W{lane_ld[g]}};
        assign ld_bits[LO +: W] = ld_data[W-1:0];
    end

    // natural modulo-2^PTR_W arithmetic gives the wrap to zero
    assign ptr_stepped = inc ? (ptr_q + PTR_W'(1)) : ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= (ptr_stepped & ~ld_mask) | (ld_bits & ld_mask);
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/wram_port_fsm.sv
module wram_port_fsm
    import wram_port_pkg::*;
#(
    parameter int PTR_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_rd,
    input  logic             data_wr,
    input  logic [PTR_W-1:0] ptr,
    input  logic [7:0]       wdata,
    input  logic [7:0]       ram_rdata,
    output logic             ptr_inc,
    output logic [PTR_W-1:0] acc_addr,
    output logic             ram_we,
    output logic [7:0]       ram_wdata,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             busy
);

    port_state_t      state_q;
    port_state_t      state_d;
    logic [PTR_W-1:0] acc_addr_q;
    logic [7:0]       wdata_q;
    logic [7:0]       rdata_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (data_wr) begin
                    state_d = ST_WR_COMMIT;      // write accept
                end else if (data_rd) begin
                    state_d = ST_RD_ADDR;        // read accept
                end
            end
            ST_WR_COMMIT: state_d = ST_IDLE;     // write retire
            ST_RD_ADDR:   state_d = ST_RD_LATCH; // read fetch
            ST_RD_LATCH:  state_d = ST_RD_DONE;  // read capture
            ST_RD_DONE:   state_d = ST_IDLE;     // read retire
            default:      state_d = ST_IDLE;
        endcase
    end

    // access address and data are frozen at accept time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr_q <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && (data_wr || data_rd)) begin
                acc_addr_q <= ptr;
                wdata_q    <= wdata;
            end
            if (state_q == ST_RD_LATCH) begin
                rdata_q <= ram_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        ptr_inc  = 1'b0;
        ram_we   = 1'b0;
        rd_valid = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                ptr_inc = data_wr || data_rd;
            end
            ST_WR_COMMIT: ram_we   = 1'b1;
            ST_RD_ADDR:   ;
            ST_RD_LATCH:  ;
            ST_RD_DONE:   rd_valid = 1'b1;
            default:      busy     = 1'b1;
        endcase
    end

    assign acc_addr  = acc_addr_q;
    assign ram_wdata = wdata_q;
    assign rd_data   = rdata_q;

endmodule

// File: rtl/wram_port.sv
module wram_port #(
    parameter int                BUS_AW    = 16,
    parameter logic [BUS_AW-1:0] PORT_BASE = 16'h2180,
    parameter int                PTR_W     = 17,
    parameter int                RAM_AW    = 24,
    parameter logic [RAM_AW-1:0] BANK_BASE = 24'h7E0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    output logic              port_busy,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              ram_we
);

    localparam int NLANES = (PTR_W + 7) / 8;

    logic              data_rd;
    logic              data_wr;
    logic [NLANES-1:0] lane_ld;
    logic              ptr_inc;
    logic [PTR_W-1:0]  ptr;
    logic [PTR_W-1:0]  acc_addr;

    wram_port_decode #(
        .BUS_AW   (BUS_AW),
        .PORT_BASE(PORT_BASE),
        .NLANES   (NLANES)
    ) u_decode (
        .bus_addr(bus_addr),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .data_rd (data_rd),
        .data_wr (data_wr),
        .lane_ld (lane_ld)
    );

    wram_ptr_reg #(
        .PTR_W (PTR_W),
        .NLANES(NLANES)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane_ld(lane_ld),
        .ld_data(bus_wdata),
        .inc    (ptr_inc),
        .ptr    (ptr)
    );

    wram_port_fsm #(
        .PTR_W(PTR_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_rd  (data_rd),
        .data_wr  (data_wr),
        .ptr      (ptr),
        .wdata    (bus_wdata),
        .ram_rdata(ram_rdata),
        .ptr_inc  (ptr_inc),
        .acc_addr (acc_addr),
        .ram_we   (ram_we),
        .ram_wdata(ram_wdata),
        .rd_valid (bus_rvalid),
        .rd_data  (bus_rdata),
        .busy     (port_busy)
    );

    assign ram_addr = BANK_BASE | RAM_AW'(acc_addr);

endmodule

// File: rtl/wram_port_chk.sv
module wram_port_chk #(
    parameter int                BUS_AW    = 16,
    parameter logic [BUS_AW-1:0] PORT_BASE = 16'h2180,
    parameter int                PTR_W     = 17,
    parameter int                RAM_AW    = 24,
    parameter logic [RAM_AW-1:0] BANK_BASE = 24'h7E0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_rvalid,
    input logic              port_busy,
    input logic [RAM_AW-1:0] ram_addr,
    input logic [7:0]        ram_wdata,
    input logic              ram_we
);

    localparam logic [RAM_AW-1:0] BANK_MASK = ~RAM_AW'({PTR_W{1'b1}});

    logic dp_wr;
    logic dp_rd;
    assign dp_wr = bus_wr && (bus_addr == PORT_BASE);
    assign dp_rd = bus_rd && (bus_addr == PORT_BASE);

    // input assumption: data-port accesses only while idle (R9)
    p_no_dp_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        port_busy |-> !(dp_wr || dp_rd));

    p_wr_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr && !port_busy) |=> (ram_we && ram_wdata == $past(bus_wdata)));

    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    p_bank_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ((ram_addr & BANK_MASK) == BANK_BASE));

    p_read_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_rd && !port_busy) |=> ##1 (!bus_rvalid) ##1 bus_rvalid);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    p_valid_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> port_busy);

    p_idle_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !port_busy);

endmodule

bind wram_port wram_port_chk #(
    .BUS_AW   (BUS_AW),
    .PORT_BASE(PORT_BASE),
    .PTR_W    (PTR_W),
    .RAM_AW   (RAM_AW),
    .BANK_BASE(BANK_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rvalid(bus_rvalid),
    .port_busy (port_busy),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we)
);

// File: tb/wram_port_tb.sv
module wram_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;
    // vector: {op[1:0], offset[15:0], data[7:0]}; op 0 = pointer reg write,
    // 1 = data-port write, 2 = data-port read with data as expected byte
    localparam logic [25:0] VEC [NVEC] = '{
        {2'd0, 16'h2181, 8'h34},
        {2'd0, 16'h2182, 8'h12},
        {2'd0, 16'h2183, 8'hFE},
        {2'd1, 16'h2180, 8'hA5},
        {2'd1, 16'h2180, 8'h5A},
        {2'd0, 16'h2181, 8'h34},
        {2'd2, 16'h2180, 8'hA5},
        {2'd2, 16'h2180, 8'h5A},
        {2'd0, 16'h2183, 8'h01},
        {2'd1, 16'h2180, 8'h77},
        {2'd0, 16'h2181, 8'h36},
        {2'd2, 16'h2180, 8'h77},
        {2'd0, 16'h2182, 8'h00},
        {2'd1, 16'h2180, 8'h19}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic        port_busy;
    logic [23:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;
    logic        ram_we;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [16:0] ptr_m = '0;
    logic [7:0]  mem [4096];

    always #(CLK_PERIOD / 2) clk = ~clk;

    wram_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .port_busy (port_busy),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we)
    );

    // behavioural synchronous RAM, folded to 4096 bytes
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr[11:0]] <= ram_wdata;
        ram_rdata <= mem[ram_addr[11:0]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    task automatic reg_wr(input logic [15:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_addr = off; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        unique case (off)
            16'h2181: ptr_m[7:0]  = d;
            16'h2182: ptr_m[15:8] = d;
            16'h2183: ptr_m[16]   = d[0];
            default: ;
        endcase
    endtask

    task automatic data_wr(input string tag, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 16'h2180; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk({tag, " we"},    32'(ram_we), 32'd1);
        chk({tag, " addr"},  32'(ram_addr), 32'h7E0000 | 32'(ptr_m));
        chk({tag, " wdata"}, 32'(ram_wdata), 32'(d));
        ptr_m = ptr_m + 17'd1;
        @(negedge clk);
        chk({tag, " idle"},  32'(port_busy), 32'd0);
    endtask

    // optional pointer write placed in the completion cycle (R8)
    task automatic data_rd(input string tag, input logic [7:0] exp,
                           input bit late_wr, input logic [7:0] late_lo);
        @(negedge clk);
        bus_addr = 16'h2180; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk({tag, " addr"}, 32'(ram_addr), 32'h7E0000 | 32'(ptr_m));
        ptr_m = ptr_m + 17'd1;
        @(negedge clk);
        chk({tag, " early valid"}, 32'(bus_rvalid), 32'd0);
        @(negedge clk);
        chk({tag, " valid"}, 32'(bus_rvalid), 32'd1);
        chk({tag, " data"},  32'(bus_rdata), 32'(exp));
        chk({tag, " busy"},  32'(port_busy), 32'd1);
        if (late_wr) begin
            bus_addr = 16'h2181; bus_wdata = late_lo; bus_wr = 1'b1;
        end
        @(negedge clk);
        bus_wr = 1'b0;
        if (late_wr) ptr_m[7:0] = late_lo;
        chk({tag, " valid drop"}, 32'(bus_rvalid), 32'd0);
        chk({tag, " idle"},       32'(port_busy), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(port_busy), 32'd0);
        chk("R1 rvalid", 32'(bus_rvalid), 32'd0);
        chk("R1 we", 32'(ram_we), 32'd0);
        rst_n = 1'b1;
        data_wr("R1 first write at zero", 8'hE1);

        // vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [15:0] off;
            logic [7:0]  d;
            {op, off, d} = VEC[i];
            unique case (op)
                2'd0:    reg_wr(off, d);
                2'd1:    data_wr($sformatf("R5 vec%0d", i), d);
                default: data_rd($sformatf("R6 vec%0d", i), d, 1'b0, 8'h00);
            endcase
        end

        // R4: upper data bits of 0x2183 ignored, bits 15:0 kept
        reg_wr(16'h2181, 8'h40);
        reg_wr(16'h2182, 8'hAB);
        reg_wr(16'h2183, 8'hFE);
        data_wr("R4 top bits ignored", 8'h44);

        // R7: wrap from 0x1FFFF to zero
        reg_wr(16'h2181, 8'hFF);
        reg_wr(16'h2182, 8'hFF);
        reg_wr(16'h2183, 8'h01);
        data_wr("R7 last address", 8'hC3);
        data_wr("R7 wrapped", 8'h3C);
        reg_wr(16'h2183, 8'h01);
        reg_wr(16'h2181, 8'hFF);
        reg_wr(16'h2182, 8'hFF);
        data_rd("R7 readback last", 8'hC3, 1'b0, 8'h00);
        data_rd("R7 readback wrapped", 8'h3C, 1'b0, 8'h00);

        // R8: pointer write in the read completion cycle
        reg_wr(16'h2183, 8'h00);
        reg_wr(16'h2182, 8'h12);
        reg_wr(16'h2181, 8'h34);
        data_rd("R8 old pointer byte", 8'hA5, 1'b1, 8'h90);
        data_wr("R8 written pointer kept", 8'h6E);

        // R1: mid-run reset clears the pointer
        reg_wr(16'h2181, 8'h55);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ptr_m = '0;
        data_wr("R1 pointer cleared", 8'h0D);

        summary();
    end

endmodule